// File: doc/BRIEF.md
# Multiplexed DRAM Address and Strobe Controller

This block sits between a memory requester and a multiplexed DRAM array of up to four banks. It captures a row address, a column address and a bank number through transparent latches controlled by an address strobe. It then places the row, the column or an internal refresh count on a shared address bus, and it produces the active-low row strobes, the column strobe and the write enable for the array.

A three-bit mode input chooses between refresh cycles, where every bank is strobed at once and the column strobe is held off, and access cycles, where a single bank is strobed and the column strobe follows the row/column select and, in some modes, an inhibit input. Chip select gates all outputs, except that a refresh mode keeps them driven. Every output is registered on the system clock, so strobe edges are free of glitches and trail their inputs by one cycle.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: The mode input is decoded as follows: 000, 001 and 010 are refresh modes; 011 is all-bank access; 100 is externally timed access; 101 and 110 are auto access; 111 is end-of-count setting. In mode 111 all row strobes and the column strobe stay high.
- R2: The row, column and bank latches pass their inputs through while `addr_stb` is high. From the clock edge where `addr_stb` is first sampled low, they hold the value captured at the last edge where it was high.
- R3: In modes 100, 101 and 110 with outputs enabled, bit b of `ras_n_o` equals `ras_in_n` when the latched bank equals b. All other bits are 1.
- R4: In the refresh modes and in mode 011 with outputs enabled, all four bits of `ras_n_o` equal `ras_in_n`.
- R5: In the refresh modes, `cas_n_o` is 1.
- R6: In modes 011 and 100 with outputs enabled, `cas_n_o` is the OR of `rc_sel` and `cas_in`. The column strobe goes low only when `rc_sel` is low, and a high `cas_in` inhibits it.
- R7: In modes 101 and 110 with outputs enabled, `cas_n_o` equals `rc_sel`, and `cas_in` has no effect.
- R8: With outputs enabled, `we_n_o` equals `we_in_n`.
- R9: With outputs enabled, `addr_o` carries the refresh count in the refresh modes. In the other modes it carries the latched row when `rc_sel` is 1 and the latched column when `rc_sel` is 0.
- R10: The refresh count resets to 0. It increases by one, wrapping at 2^ADDR_W, on every clock edge where the block is in a refresh mode, `ras_in_n` is 1 and `ras_in_n` was 0 at the previous edge. It does not change outside the refresh modes.
- R11: Outputs are enabled when `cs_n` is 0 or when the mode is a refresh mode. While outputs are disabled, `ras_n_o` is 4'hF, `cas_n_o` and `we_n_o` are 1, `addr_o` is 0 and `addr_oe` is 0. `addr_oe` is 1 while outputs are enabled.
- R12: All outputs are registered and show the effect of their inputs one clock edge later. Reset drives `ras_n_o`=4'hF, `cas_n_o`=1, `we_n_o`=1, `addr_o`=0 and `addr_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Operating mode select |
| addr_stb | input | 1 | Address strobe, latches transparent while high |
| row_in | input | ADDR_W | Row address |
| col_in | input | ADDR_W | Column address |
| bank_in | input | BANK_W | Bank number |
| rc_sel | input | 1 | Row (1) / column (0) select |
| ras_in_n | input | 1 | Row strobe request, active low |
| cas_in | input | 1 | Column strobe input / inhibit |
| we_in_n | input | 1 | Write enable request, active low |
| cs_n | input | 1 | Chip select, active low |
| addr_o | output | ADDR_W | Multiplexed DRAM address |
| addr_oe | output | 1 | Address bus drive enable |
| ras_n_o | output | NBANK | Per-bank row strobes, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |

## Verification
The main sweep applies every combination of mode, bank, row/column select, column input, row strobe request and chip select, with row and column values that change from step to step. This separates the single-bank decode from the all-bank modes, and the inhibiting column modes from the auto modes. It also separates deselected idling from refresh, which overrides chip select. A latch sequence changes the address inputs after the strobe falls, so captured values can be told apart from transparent ones. A run of refresh pulses drives the counter across its wrap point. A single-edge probe of write enable confirms the one-cycle output latency.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [2:0] {
        MD_EXT_RFSH   = 3'b000,
        MD_AUTO_RFSH  = 3'b001,
        MD_BURST_RFSH = 3'b010,
        MD_ALLROW_ACC = 3'b011,
        MD_EXT_ACC    = 3'b100,
        MD_AUTO_SLOW  = 3'b101,
        MD_AUTO_FAST  = 3'b110,
        MD_SET_EOC    = 3'b111
    } mode_e;

    function automatic logic is_refresh(mode_e m);
        return (m == MD_EXT_RFSH) || (m == MD_AUTO_RFSH) || (m == MD_BURST_RFSH);
    endfunction

    function automatic logic is_all_rows(mode_e m);
        return is_refresh(m) || (m == MD_ALLROW_ACC);
    endfunction

    function automatic logic is_inhibit_mode(mode_e m);
        return (m == MD_ALLROW_ACC) || (m == MD_EXT_ACC);
    endfunction

    function automatic logic is_auto_mode(mode_e m);
        return (m == MD_AUTO_SLOW) || (m == MD_AUTO_FAST);
    endfunction

endpackage

// File: rtl/dsc_latch.sv
module dsc_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stb,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] hold;

    always_ff @(posedge clk) begin
        if (rst)
            hold <= '0;
        else if (stb)
            hold <= d;
    end

    assign q = stb ? d : hold;

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(hold)); // R2

endmodule

// File: rtl/dsc_rfsh_ctr.sv
module dsc_rfsh_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  logic         ras_in_n,
    output logic [W-1:0] count
);
    logic ras_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_prev <= 1'b1;
            count    <= '0;
        end else begin
            ras_prev <= ras_in_n;
            if (active && !ras_prev && ras_in_n)
                count <= count + 1'b1;
        end
    end

    AST_CTR_IDLE: assert property (@(posedge clk) disable iff (rst)
        !active |=> $stable(count)); // R10

endmodule

// File: rtl/dsc_strobe_gen.sv
module dsc_strobe_gen
    import dsc_pkg::*;
#(
    parameter int NBANK = 4,
    localparam int BANK_W = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst,
    input  mode_e             mode,
    input  logic              en,
    input  logic [BANK_W-1:0] bank,
    input  logic              ras_in_n,
    input  logic              rc_sel,
    input  logic              cas_in,
    input  logic              we_in_n,
    output logic [NBANK-1:0]  ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o
);
    logic [NBANK-1:0] bank_hit;
    logic [NBANK-1:0] ras_nx;
    logic             cas_nx;

    for (genvar g = 0; g < NBANK; g++) begin : g_dec
        assign bank_hit[g] = (bank == BANK_W'(g));
        always_comb begin
            if (!en || mode == MD_SET_EOC)
                ras_nx[g] = 1'b1;
            else if (is_all_rows(mode))
                ras_nx[g] = ras_in_n;
            else
                ras_nx[g] = bank_hit[g] ? ras_in_n : 1'b1;
        end
    end

    always_comb begin
        if (!en || is_refresh(mode) || mode == MD_SET_EOC)
            cas_nx = 1'b1;
        else if (is_inhibit_mode(mode))
            cas_nx = rc_sel | cas_in;
        else
            cas_nx = rc_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_n_o <= '1;
            cas_n_o <= 1'b1;
            we_n_o  <= 1'b1;
        end else begin
            ras_n_o <= ras_nx;
            cas_n_o <= cas_nx;
            we_n_o  <= en ? we_in_n : 1'b1;
        end
    end

    AST_RFSH_CAS_HIGH: assert property (@(posedge clk) disable iff (rst)
        is_refresh(mode) |=> cas_n_o); // R5

    AST_RAS_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
        !is_all_rows(mode) |=> ($countones(~ras_n_o) <= 1)); // R3

    AST_WE_COPY: assert property (@(posedge clk) disable iff (rst)
        en |=> (we_n_o == $past(we_in_n))); // R8

    AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        !en |=> (&ras_n_o) && cas_n_o && we_n_o); // R11

    AST_AUTO_IGNORES_CAS_IN: assert property (@(posedge clk) disable iff (rst)
        (en && is_auto_mode(mode)) |=> (cas_n_o == $past(rc_sel))); // R7

endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl
    import dsc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NBANK = 4,
    localparam int BANK_W = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_sel,
    input  logic              addr_stb,
    input  logic [ADDR_W-1:0] row_in,
    input  logic [ADDR_W-1:0] col_in,
    input  logic [BANK_W-1:0] bank_in,
    input  logic              rc_sel,
    input  logic              ras_in_n,
    input  logic              cas_in,
    input  logic              we_in_n,
    input  logic              cs_n,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_oe,
    output logic [NBANK-1:0]  ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o
);
    mode_e             mode;
    logic              rfsh;
    logic              en;
    logic [ADDR_W-1:0] row_q;
    logic [ADDR_W-1:0] col_q;
    logic [BANK_W-1:0] bank_q;
    logic [ADDR_W-1:0] rfsh_cnt;
    logic [ADDR_W-1:0] addr_nx;

    assign mode = mode_e'(mode_sel);
    assign rfsh = is_refresh(mode);
    assign en   = !cs_n || rfsh;

    dsc_latch #(.W(ADDR_W)) u_row (
        .clk(clk), .rst(rst), .stb(addr_stb), .d(row_in), .q(row_q));
    dsc_latch #(.W(ADDR_W)) u_col (
        .clk(clk), .rst(rst), .stb(addr_stb), .d(col_in), .q(col_q));
    dsc_latch #(.W(BANK_W)) u_bank (
        .clk(clk), .rst(rst), .stb(addr_stb), .d(bank_in), .q(bank_q));

    dsc_rfsh_ctr #(.W(ADDR_W)) u_ctr (
        .clk(clk), .rst(rst), .active(rfsh), .ras_in_n(ras_in_n), .count(rfsh_cnt));

    dsc_strobe_gen #(.NBANK(NBANK)) u_stb (
        .clk(clk), .rst(rst), .mode(mode), .en(en), .bank(bank_q),
        .ras_in_n(ras_in_n), .rc_sel(rc_sel), .cas_in(cas_in), .we_in_n(we_in_n),
        .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o));

    always_comb begin
        if (!en)
            addr_nx = '0;
        else if (rfsh)
            addr_nx = rfsh_cnt;
        else if (rc_sel)
            addr_nx = row_q;
        else
            addr_nx = col_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o  <= '0;
            addr_oe <= 1'b0;
        end else begin
            addr_o  <= addr_nx;
            addr_oe <= en;
        end
    end

    AST_OE_TRACKS_SELECT: assert property (@(posedge clk) disable iff (rst)
        (cs_n && !rfsh) |=> !addr_oe && (addr_o == '0)); // R11

    AST_RFSH_KEEPS_ON: assert property (@(posedge clk) disable iff (rst)
        rfsh |=> addr_oe); // R11

    AST_EOC_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_SET_EOC) |=> (&ras_n_o) && cas_n_o); // R1

endmodule

// File: tb/sim_dram_strobe_ctrl.sv
`timescale 1ns/1ps
module sim_dram_strobe_ctrl;
    localparam int AW = 8;
    localparam int NB = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] mode_sel = 3'b100;
    logic addr_stb = 1'b1;
    logic [AW-1:0] row_in = '0, col_in = '0;
    logic [1:0] bank_in = '0;
    logic rc_sel = 1'b1, ras_in_n = 1'b1, cas_in = 1'b1, we_in_n = 1'b1, cs_n = 1'b0;
    logic [AW-1:0] addr_o;
    logic addr_oe, cas_n_o, we_n_o;
    logic [NB-1:0] ras_n_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [AW-1:0] m_cnt = '0;
    logic m_prev = 1'b1;

    always #2 clk = ~clk;

    dram_strobe_ctrl #(.ADDR_W(AW), .NBANK(NB)) u0 (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // model counter update for one applied edge
    task automatic ctr_step(input logic [2:0] m, input logic r);
        if (m <= 3'd2 && !m_prev && r) m_cnt = m_cnt + 1'b1;
        m_prev = r;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R12 reset ras", ras_n_o, 4'hF);
        chk("R12 reset cas", cas_n_o, 1);
        chk("R12 reset we", we_n_o, 1);
        chk("R12 reset addr", addr_o, 0);
        chk("R12 reset oe", addr_oe, 0);
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #1;
        ctr_step(3'b100, 1'b1);

        // R12 latency: change lands only at the next edge
        @(negedge clk) we_in_n = 1'b0;
        #1 chk("R12 before edge", we_n_o, 1);
        @(posedge clk); #1;
        chk("R12 after edge", we_n_o, 0);
        ctr_step(3'b100, 1'b1);

        // exhaustive sweep over modes and controls
        for (int i = 0; i < 512; i++) begin
            logic [2:0] m; logic [1:0] b; logic rc, ci, ra, cs, we, refr, en;
            logic [3:0] ras_e; logic cas_e, we_e; logic [AW-1:0] a_e, rw, cl;
            m = i[8:6]; b = i[5:4]; rc = i[3]; ci = i[2]; ra = i[1]; cs = i[0];
            we = i[3] ^ i[1];
            rw = AW'(i * 7 + 3); cl = AW'(i * 13 + 101);
            @(negedge clk);
            mode_sel = m; bank_in = b; rc_sel = rc; cas_in = ci; ras_in_n = ra;
            cs_n = cs; we_in_n = we; row_in = rw; col_in = cl; addr_stb = 1'b1;
            refr = (m <= 3'd2);
            en = !cs || refr;
            if (!en || m == 3'd7) ras_e = 4'hF;
            else if (refr || m == 3'd3) ras_e = {4{ra}};
            else ras_e = 4'hF & ~({3'b0, ~ra} << b);
            if (!en || refr || m == 3'd7) cas_e = 1'b1;
            else if (m == 3'd3 || m == 3'd4) cas_e = rc | ci;
            else cas_e = rc;
            we_e = en ? we : 1'b1;
            a_e = !en ? '0 : refr ? m_cnt : rc ? rw : cl;
            @(posedge clk); #1;
            chk(!en ? "R11 ras" : m == 3'd7 ? "R1 ras" : (refr || m == 3'd3) ? "R4 ras" : "R3 ras",
                ras_n_o, ras_e);
            chk(!en ? "R11 cas" : (refr || m == 3'd7) ? "R5 cas" :
                (m == 3'd3 || m == 3'd4) ? "R6 cas" : "R7 cas", cas_n_o, cas_e);
            chk("R8 we", we_n_o, we_e);
            chk("R9 addr", addr_o, a_e);
            chk("R11 oe", addr_oe, en);
            ctr_step(m, ra);
        end

        // R2: latched values held after the strobe falls
        @(negedge clk);
        mode_sel = 3'b100; cs_n = 0; addr_stb = 1; row_in = 8'h5A; col_in = 8'h3C;
        bank_in = 2'd2; rc_sel = 1; ras_in_n = 1; cas_in = 0;
        @(posedge clk); #1; ctr_step(3'b100, 1'b1);
        @(negedge clk);
        addr_stb = 0; row_in = 8'hFF; col_in = 8'h00; bank_in = 2'd0; ras_in_n = 0;
        @(posedge clk); #1; ctr_step(3'b100, 1'b0);
        chk("R2 row hold", addr_o, 8'h5A);
        chk("R2 bank hold", ras_n_o, 4'b1011);
        @(negedge clk) rc_sel = 0;
        @(posedge clk); #1; ctr_step(3'b100, 1'b0);
        chk("R2 col hold", addr_o, 8'h3C);
        chk("R6 cas after rc low", cas_n_o, 0);
        @(negedge clk) cas_in = 1;
        @(posedge clk); #1; ctr_step(3'b100, 1'b0);
        chk("R6 cas inhibited", cas_n_o, 1);

        // R10: refresh pulses across the wrap point, chip deselected
        @(negedge clk); mode_sel = 3'b000; cs_n = 1; ras_in_n = 1;
        @(posedge clk); #1; ctr_step(3'b000, 1'b1);
        for (int p = 0; p < 300 && m_cnt != 8'hFF; p++) begin
            @(negedge clk) ras_in_n = 0;
            @(posedge clk); #1; ctr_step(3'b000, 1'b0);
            @(negedge clk) ras_in_n = 1;
            @(posedge clk); #1; ctr_step(3'b000, 1'b1);
        end
        @(negedge clk);
        @(posedge clk); #1; ctr_step(3'b000, 1'b1);
        chk("R10 count at top", addr_o, 8'hFF);
        chk("R11 refresh overrides cs", addr_oe, 1);
        @(negedge clk) ras_in_n = 0;
        @(posedge clk); #1; ctr_step(3'b000, 1'b0);
        @(negedge clk) ras_in_n = 1;
        @(posedge clk); #1; ctr_step(3'b000, 1'b1);
        @(negedge clk);
        @(posedge clk); #1; ctr_step(3'b000, 1'b1);
        chk("R10 count wrapped", addr_o, 8'h00);
        chk("R10 model wrapped", m_cnt, 8'h00);

        done = 1;
        summary();
    end
endmodule